// File: doc/BRIEF.md
# Bank Conflict Serializer for a Word-Banked Scratchpad

This block owns a small on-chip scratchpad split into independent banks, each one word wide, and services a wide gather read: one request carries a word address for every lane of a SIMT group together with a lane-enable mask. Lanes whose addresses fall in different banks are read in the same cycle. Lanes that reach the same bank at different words must take turns, so the block splits the request into passes. In each pass every bank delivers at most one word. Lanes asking for the very same word are all fed from that single bank read.

The requester raises `rd_req` for one cycle while the block is idle. The block then reports `busy` until the last pass has returned data. It then pulses `done` once and presents the whole per-lane result vector and the number of passes used. These outputs hold until the next request is accepted. A separate single-word write port fills the storage. It has no arbitration against reads.

Top module: `bank_conflict_serializer`

## Requirements
- R1: A word address selects bank `addr % NUM_BANKS` (its low bits) and row `addr / NUM_BANKS` (its high bits). A word written through `wr_en`/`wr_addr`/`wr_data` is what later reads of that address return.
- R2: While and directly after reset, `busy` and `done` are 0, `pass_cnt` is 0 and every lane of `rd_data` is zero.
- R3: For an accepted request, `pass_cnt` equals the largest number of distinct active addresses that map to any single bank. Every active lane receives the word stored at its address.
- R4: Thirty-two active lanes at stride 32 words all land in bank 0 and take 32 passes.
- R5: Thirty-two active lanes at stride 33 words land in 32 distinct banks and take a single pass.
- R6: Active lanes sharing one word address are served together in one pass and add nothing to the pass count.
- R7: A lane whose mask bit is 0 returns zero and its address does not affect the pass count. An all-zero mask yields zero passes.
- R8: If a request is accepted at clock edge E, `busy` is 1 after E and stays 1 for P further edges, where P is the pass count. At edge E+P+1, `busy` falls and `done` is 1 for exactly one cycle, together with valid results.
- R9: A `rd_req` raised while `busy` is 1 is ignored. The running request completes with its own addresses and mask.
- R10: After `done`, `rd_data` and `pass_cnt` keep their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one word this cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | WORD_W | Data to write |
| rd_req | input | 1 | Start a gather read (accepted only when idle) |
| rd_mask | input | NUM_LANES | Active-lane mask, bit l enables lane l |
| rd_addr | input | NUM_LANES*ADDR_W | Word address of lane l at bits [l*ADDR_W +: ADDR_W] |
| busy | output | 1 | A request is being serviced |
| done | output | 1 | One-cycle pulse: results are valid |
| pass_cnt | output | CNT_W | Passes used by the last request |
| rd_data | output | NUM_LANES*WORD_W | Word of lane l at bits [l*WORD_W +: WORD_W] |

## Verification
The bench uses the package defaults: 32 lanes, 32 banks and 32 rows per bank, which gives a 1024-word space with a 10-bit address. That space is large enough for 32 lanes at strides 32 and 33 without address wrap, so both the full 32-pass worst case and the padded single-pass case appear as they would at full scale. Broadcast pairs, masked conflicting lanes, an empty mask, stride 2 and pseudo-random gathers cover pass counts between 0 and 32. A reference model compares `busy` and `done` on every clock of each request.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    parameter int unsigned NUM_LANES  = 32;
    parameter int unsigned NUM_BANKS  = 32;   // power of two: bank = low address bits
    parameter int unsigned BANK_DEPTH = 32;
    parameter int unsigned WORD_W     = 32;

    localparam int unsigned BANK_W = $clog2(NUM_BANKS);
    localparam int unsigned ROW_W  = $clog2(BANK_DEPTH);
    localparam int unsigned ADDR_W = BANK_W + ROW_W;
    localparam int unsigned CNT_W  = $clog2(NUM_LANES + 1);

    typedef logic [ADDR_W-1:0]    waddr_t;
    typedef logic [BANK_W-1:0]    bank_t;
    typedef logic [ROW_W-1:0]     row_t;
    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [NUM_LANES-1:0] lane_mask_t;
    typedef logic [CNT_W-1:0]     cnt_t;

    typedef struct packed {
        logic en;
        row_t row;
    } bank_rd_t;

    typedef enum logic {ST_IDLE, ST_RUN} state_t;

    function automatic bank_t bank_of(waddr_t a);
        return a[BANK_W-1:0];
    endfunction

    function automatic row_t row_of(waddr_t a);
        return a[ADDR_W-1:BANK_W];
    endfunction
endpackage

// File: rtl/bcs_arbiter.sv
module bcs_arbiter
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  waddr_t     lane_addr [NUM_LANES],
    input  lane_mask_t pending,
    output lane_mask_t serve,
    output bank_rd_t   bank_rd   [NUM_BANKS]
);
    waddr_t sel_addr [NUM_BANKS];
    logic   sel_hit  [NUM_BANKS];

    // Per bank: the lowest-numbered pending lane picks the word for this pass.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            sel_addr[b] = '0;
            sel_hit[b]  = 1'b0;
            for (int l = NUM_LANES - 1; l >= 0; l--) begin
                if (pending[l] && bank_of(lane_addr[l]) == bank_t'(b)) begin
                    sel_addr[b] = lane_addr[l];
                    sel_hit[b]  = 1'b1;
                end
            end
            bank_rd[b].en  = sel_hit[b];
            bank_rd[b].row = row_of(sel_addr[b]);
        end
    end

    // Every pending lane asking for its bank's chosen word rides along (broadcast).
    always_comb begin
        for (int l = 0; l < NUM_LANES; l++) begin
            serve[l] = pending[l] && (lane_addr[l] == sel_addr[bank_of(lane_addr[l])]);
        end
    end

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
        (pending != '0) |-> ((serve & pending & (~pending + lane_mask_t'(1))) != '0)); // R3
endmodule

// File: rtl/bcs_banks.sv
module bcs_banks
    import bcs_pkg::*;
(
    input  logic     clk,
    input  logic     wr_en,
    input  waddr_t   wr_addr,
    input  word_t    wr_data,
    input  bank_rd_t bank_rd [NUM_BANKS],
    output word_t    bank_q  [NUM_BANKS]
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        word_t mem [BANK_DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && bank_of(wr_addr) == bank_t'(b)) begin
                mem[row_of(wr_addr)] <= wr_data;
            end
            if (bank_rd[b].en) begin
                bank_q[b] <= mem[bank_rd[b].row];
            end
        end
    end
endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
    import bcs_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic                          rd_req,
    input  logic [NUM_LANES-1:0]          rd_mask,
    input  logic [NUM_LANES*ADDR_W-1:0]   rd_addr,
    output logic                          busy,
    output logic                          done,
    output logic [CNT_W-1:0]              pass_cnt,
    output logic [NUM_LANES*WORD_W-1:0]   rd_data
);
    state_t     state;
    waddr_t     lane_addr [NUM_LANES];
    lane_mask_t mask_q;
    lane_mask_t pending;
    lane_mask_t serve;
    lane_mask_t cap_mask;
    logic       cap_valid;
    cnt_t       cnt;
    logic       done_q;
    word_t      result    [NUM_LANES];
    bank_rd_t   bank_rd   [NUM_BANKS];
    word_t      bank_q    [NUM_BANKS];

    bcs_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .lane_addr (lane_addr),
        .pending   (pending),
        .serve     (serve),
        .bank_rd   (bank_rd)
    );

    bcs_banks u_banks (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank_rd (bank_rd),
        .bank_q  (bank_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mask_q    <= '0;
            pending   <= '0;
            cap_mask  <= '0;
            cap_valid <= 1'b0;
            cnt       <= '0;
            done_q    <= 1'b0;
            for (int l = 0; l < NUM_LANES; l++) begin
                lane_addr[l] <= '0;
                result[l]    <= '0;
            end
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (rd_req) begin
                        for (int l = 0; l < NUM_LANES; l++) begin
                            lane_addr[l] <= rd_addr[l*ADDR_W +: ADDR_W];
                            result[l]    <= '0;
                        end
                        mask_q    <= rd_mask;
                        pending   <= rd_mask;
                        cnt       <= '0;
                        cap_valid <= 1'b0;
                        state     <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    // Capture the words read in the previous pass.
                    if (cap_valid) begin
                        for (int l = 0; l < NUM_LANES; l++) begin
                            if (cap_mask[l]) begin
                                result[l] <= bank_q[bank_of(lane_addr[l])];
                            end
                        end
                    end
                    if (pending != '0) begin
                        pending   <= pending & ~serve;
                        cap_mask  <= serve;
                        cap_valid <= 1'b1;
                        cnt       <= cnt + cnt_t'(1);
                    end else begin
                        cap_valid <= 1'b0;
                        done_q    <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state == ST_RUN);
    assign done     = done_q;
    assign pass_cnt = cnt;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_out
        assign rd_data[l*WORD_W +: WORD_W] = result[l];

        AST_MASKED_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
            done |-> (mask_q[l] || result[l] == '0)); // R7
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && pending == '0)); // R8

    AST_PENDING_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (busy && pending != '0) |=> ($countones(pending) < $countones($past(pending)))); // R3

    AST_PASS_BOUND: assert property (@(posedge clk) disable iff (rst)
        pass_cnt <= cnt_t'(NUM_LANES)); // R3

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mask_q)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !rd_req) |=> ($stable(rd_data) && $stable(pass_cnt))); // R10
endmodule

// File: tb/bank_conflict_serializer_tb.sv
module bank_conflict_serializer_tb_top;
    import bcs_pkg::*;

    localparam int unsigned WORDS = NUM_BANKS * BANK_DEPTH;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic                        wr_en = 1'b0;
    logic [ADDR_W-1:0]           wr_addr = '0;
    logic [WORD_W-1:0]           wr_data = '0;
    logic                        rd_req = 1'b0;
    logic [NUM_LANES-1:0]        rd_mask = '0;
    logic [NUM_LANES*ADDR_W-1:0] rd_addr = '0;
    logic                        busy;
    logic                        done;
    logic [CNT_W-1:0]            pass_cnt;
    logic [NUM_LANES*WORD_W-1:0] rd_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    logic [WORD_W-1:0]    shadow [WORDS];
    int                   req_addr [NUM_LANES];
    logic [NUM_LANES-1:0] req_mask;
    bit                   inject;

    always #2 clk = ~clk;

    bank_conflict_serializer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_mask(rd_mask), .rd_addr(rd_addr),
        .busy(busy), .done(done), .pass_cnt(pass_cnt), .rd_data(rd_data)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic write_word(int a, logic [WORD_W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        shadow[a] = v;
    endtask

    function automatic int ref_passes();
        int per_bank [NUM_BANKS];
        int best = 0;
        for (int b = 0; b < NUM_BANKS; b++) per_bank[b] = 0;
        for (int l = 0; l < NUM_LANES; l++) begin
            bit dup = 0;
            if (!req_mask[l]) continue;
            for (int j = 0; j < l; j++)
                if (req_mask[j] && req_addr[j] == req_addr[l]) dup = 1;
            if (!dup) per_bank[req_addr[l] % NUM_BANKS]++;
        end
        for (int b = 0; b < NUM_BANKS; b++) if (per_bank[b] > best) best = per_bank[b];
        return best;
    endfunction

    task automatic check_results(string req, int exp_p);
        chk(pass_cnt == CNT_W'(exp_p), req, "pass_cnt", pass_cnt, exp_p);
        for (int l = 0; l < NUM_LANES; l++) begin
            logic [WORD_W-1:0] e = req_mask[l] ? shadow[req_addr[l]] : '0;
            chk(rd_data[l*WORD_W +: WORD_W] == e, req, $sformatf("lane %0d data", l),
                rd_data[l*WORD_W +: WORD_W], e);
        end
    endtask

    task automatic run_req(string req);
        int exp_p = ref_passes();
        @(negedge clk);
        rd_req = 1'b1;
        rd_mask = req_mask;
        for (int l = 0; l < NUM_LANES; l++) rd_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(req_addr[l]);
        @(posedge clk);
        @(negedge clk);
        rd_req = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R8", "busy after accept", {busy, done}, 2'b10);
        for (int k = 1; k <= exp_p + 1; k++) begin
            if (inject && k == 1) begin
                rd_req = 1'b1;
                rd_mask = '1;
                for (int l = 0; l < NUM_LANES; l++) rd_addr[l*ADDR_W +: ADDR_W] = ADDR_W'(l * 7 + 3);
            end
            @(posedge clk);
            @(negedge clk);
            rd_req = 1'b0;
            if (k <= exp_p)
                chk(busy == 1'b1 && done == 1'b0, "R8", $sformatf("cycle %0d in run", k), {busy, done}, 2'b10);
            else
                chk(busy == 1'b0 && done == 1'b1, "R8", "done pulse", {busy, done}, 2'b01);
        end
        check_results(req, exp_p);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done single cycle", done, 0);
        check_results("R10", exp_p);
    endtask

    initial begin
        int seed = 32'h1234_5678;
        inject = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 0 && done == 0, "R2", "busy/done in reset", {busy, done}, 0);
        chk(pass_cnt == 0, "R2", "pass_cnt in reset", pass_cnt, 0);
        chk(rd_data == '0, "R2", "rd_data in reset", rd_data[31:0], 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && rd_data == '0, "R2", "state after reset", {busy, done}, 0);

        for (int a = 0; a < WORDS; a++) write_word(a, WORD_W'(32'h3C00_0000 ^ (a * 32'h0001_0003)));

        // R1 R3: unit stride, one pass
        req_mask = '1;
        for (int l = 0; l < NUM_LANES; l++) req_addr[l] = l + 100;
        run_req("R1");

        // R4: stride 32 -> all in bank 0
        for (int l = 0; l < NUM_LANES; l++) req_addr[l] = l * 32;
        run_req("R4");

        // R5: stride 33 -> all distinct banks
        for (int l = 0; l < NUM_LANES; l++) req_addr[l] = l * 33;
        run_req("R5");

        // R6: full broadcast of one word
        for (int l = 0; l < NUM_LANES; l++) req_addr[l] = 77;
        run_req("R6");

        // R6: pairs share a word, 16 distinct words in bank 5
        for (int l = 0; l < NUM_LANES; l++) req_addr[l] = 32 * (l / 2) + 5;
        run_req("R6");

        // R3: stride 2 -> two passes
        for (int l = 0; l < NUM_LANES; l++) req_addr[l] = l * 2;
        run_req("R3");

        // R7: stride 32 with only even lanes active
        for (int l = 0; l < NUM_LANES; l++) req_addr[l] = l * 32;
        req_mask = 32'h5555_5555;
        run_req("R7");

        // R7: empty mask
        req_mask = '0;
        run_req("R7");

        // R9: request raised during a running stride-32 read
        req_mask = '1;
        for (int l = 0; l < NUM_LANES; l++) req_addr[l] = l * 32 + 9;
        inject = 1;
        run_req("R9");
        inject = 0;

        // R1: overwrite two words in bank 1 and read them back
        write_word(33, 32'hDEAD_0021);
        write_word(65, 32'hBEEF_0041);
        req_mask = '1;
        for (int l = 0; l < NUM_LANES; l++) req_addr[l] = (l % 2 == 0) ? 33 : 65;
        run_req("R1");

        // R3: pseudo-random gathers with random masks
        for (int it = 0; it < 8; it++) begin
            for (int l = 0; l < NUM_LANES; l++) begin
                seed = seed * 1103515245 + 12345;
                req_addr[l] = ((seed >>> 8) & 32'h7fff_ffff) % (it < 4 ? WORDS : 96);
            end
            seed = seed * 1103515245 + 12345;
            req_mask = NUM_LANES'(seed ^ (seed << 7));
            run_req("R3");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule